// File: doc/BRIEF.md
# Linked-List Transmit Descriptor Engine

This block walks a chain of transmit descriptors kept in system memory and turns each one into a frame on a byte stream. A descriptor is three consecutive 32-bit little-endian words: the packet buffer address, a size/flags word and a pointer to the following descriptor. For every descriptor that holds a packet, the engine reads the payload one word at a time, sends its bytes least significant first with start and end markers, then gives the descriptor back by writing its size/flags word with the empty flag set. It then follows the next pointer.

Software programs the chain pointer and writes the enable bit. The walk runs until the engine meets a descriptor that is already marked empty; it then raises a one-cycle underrun pulse and drops its enable. A one-cycle packet-sent pulse after each returned descriptor feeds a separate status block, and a loopback select travels with each frame so that the receive path can take it instead of the line. All memory traffic goes through a single word-wide master port with one access outstanding at a time.

Top module: `desc_tx_dma`

## Requirements
- R1: After reset `txEnable`, `memReq`, `txValid`, `pktSentPulse` and `underrunPulse` are all low.
- R2: A cycle with `ctlWrEn` high and `ctlEnBit` = 1, while idle and with `cfgTxEn` high, starts a walk whose first memory read is at `descPtr` with bits 1:0 forced to zero; a descriptor is read as buffer address (offset 0), size/flags (offset 4), next pointer (offset 8).
- R3: While `cfgTxEn` is low, an enable write sets `txEnable` but starts no memory access.
- R4: Each packet has the length in size/flags bits 10:0 (bits 30:11 are ignored for length); its bytes come from the word-aligned buffer, byte 0 in bits 7:0 of the first word, and the last word is trimmed; `txSof` marks the first byte and `txEof` the last.
- R5: A byte is taken when `txValid` and `txReady` are both high; while `txReady` is low, `txData`, `txSof`, `txEof` and `txLoop` hold, and no memory request is made while a byte is offered.
- R6: After the last byte of a packet is taken, the engine writes the original size/flags word with bit 31 set to descriptor offset 4, pulses `pktSentPulse` for one cycle in the cycle after that write completes, and continues at the next pointer with bits 1:0 forced to zero.
- R7: A fetched size/flags word with bit 31 set ends the walk: no byte and no write for that descriptor, one `underrunPulse`, and `txEnable` low from the same cycle.
- R8: A packet of length zero sends no byte but is still written back and counted with `pktSentPulse`.
- R9: `txLoop` equals `cfgLoopback` as sampled when the descriptor's size/flags word was read, and stays constant over the frame.
- R10: While idle, an enable write with `ctlEnBit` = 0 clears `txEnable`; any enable write during a walk is ignored.
- R11: A memory request keeps `memReq`, `memWe`, `memAddr` and `memWdata` stable until `memValid` completes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgTxEn | input | 1 | Transmit path enabled in the MAC configuration |
| cfgLoopback | input | 1 | Route frames to the receive path |
| ctlWrEn | input | 1 | Write strobe for the enable bit |
| ctlEnBit | input | 1 | Enable value being written |
| descPtr | input | 32 | Programmed first-descriptor pointer |
| txEnable | output | 1 | Current state of the enable bit |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 32 | Byte address, word aligned |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memValid |
| memValid | input | 1 | Access complete this cycle |
| txData | output | 8 | Frame byte |
| txValid | output | 1 | Byte offered |
| txReady | input | 1 | Sink takes the byte |
| txSof | output | 1 | First byte of frame |
| txEof | output | 1 | Last byte of frame |
| txLoop | output | 1 | Frame goes to the receive path |
| pktSentPulse | output | 1 | One descriptor returned |
| underrunPulse | output | 1 | Walk ended on an empty descriptor |

## Verification
The assertions assume that the memory port answers each request with exactly one `memValid` cycle while `memReq` is high and never raises it otherwise, and that `cfgLoopback` changes only between walks. The bench memory model grants only requests that are present, with a latency of zero to two cycles, and the stimulus sets configuration inputs before each walk starts. The stream sink varies `txReady` in fixed patterns so that stalls land on every byte lane and on word boundaries.

// File: rtl/desc_tx_pkg.sv
package desc_tx_pkg;
  localparam int WORD_W    = 32;
  localparam int ADDR_W    = WORD_W;
  localparam int LEN_W     = 11;
  localparam int EMPTY_BIT = 31;
  localparam int LANES     = WORD_W / 8;
  localparam int LANE_W    = $clog2(LANES);
  localparam int OFS_SIZE  = 4;
  localparam int OFS_NEXT  = 8;

  typedef enum logic [1:0] {
    SEL_DESC_BUF,
    SEL_DESC_SIZE,
    SEL_DESC_NEXT,
    SEL_PAYLOAD
  } addr_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GET_BUF,
    ST_GET_SIZE,
    ST_GET_NEXT,
    ST_GET_WORD,
    ST_SEND,
    ST_RETURN
  } walk_st_e;

  typedef struct packed {
    logic startWalk;
    logic ldBuf;
    logic ldSize;
    logic ldNext;
    logic ldWord;
    logic takeByte;
    logic advDesc;
  } dp_ctl_t;
endpackage

// File: rtl/desc_tx_datapath.sv
module desc_tx_datapath
  import desc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctl_t           dpCtl,
  input  addr_sel_e         addrSel,
  input  logic [ADDR_W-1:0] descPtr,
  input  logic              cfgLoopback,
  input  logic [WORD_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  output logic              rdEmpty,
  output logic              lenZero,
  output logic              lastByte,
  output logic              wordEnd,
  output logic [7:0]        txData,
  output logic              txSof,
  output logic              txEof,
  output logic              txLoop
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(LANES - 1);

  logic [ADDR_W-1:0] descAddr;
  logic [ADDR_W-1:0] bufAddr;
  logic [ADDR_W-1:0] nextPtr;
  logic [WORD_W-1:0] sizeWord;
  logic [WORD_W-1:0] dataWord;
  logic [LANE_W-1:0] byteIdx;
  logic [LEN_W-1:0]  bytesLeft;
  logic              firstByte;
  logic              loopSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      descAddr  <= '0;
      bufAddr   <= '0;
      nextPtr   <= '0;
      sizeWord  <= '0;
      dataWord  <= '0;
      byteIdx   <= '0;
      bytesLeft <= '0;
      firstByte <= 1'b0;
      loopSel   <= 1'b0;
    end else begin
      if (dpCtl.startWalk) descAddr <= descPtr & ALIGN_MASK;
      if (dpCtl.advDesc)   descAddr <= nextPtr;
      if (dpCtl.ldBuf)     bufAddr  <= memRdata & ALIGN_MASK;
      if (dpCtl.ldNext)    nextPtr  <= memRdata & ALIGN_MASK;
      if (dpCtl.ldSize) begin
        sizeWord  <= memRdata;
        bytesLeft <= memRdata[LEN_W-1:0];
        firstByte <= 1'b1;
        loopSel   <= cfgLoopback;
      end
      if (dpCtl.ldWord) begin
        dataWord <= memRdata;
        byteIdx  <= '0;
      end
      if (dpCtl.takeByte) begin
        byteIdx   <= byteIdx + 1'b1;
        bytesLeft <= bytesLeft - 1'b1;
        firstByte <= 1'b0;
        if (wordEnd) bufAddr <= bufAddr + ADDR_W'(LANES);
      end
    end
  end

  always_comb begin
    unique case (addrSel)
      SEL_DESC_BUF:  memAddr = descAddr;
      SEL_DESC_SIZE: memAddr = descAddr + ADDR_W'(OFS_SIZE);
      SEL_DESC_NEXT: memAddr = descAddr + ADDR_W'(OFS_NEXT);
      default:       memAddr = bufAddr;
    endcase
  end

  assign memWdata = sizeWord | (WORD_W'(1) << EMPTY_BIT);
  assign rdEmpty  = memRdata[EMPTY_BIT];
  assign lenZero  = (bytesLeft == '0);
  assign lastByte = (bytesLeft == LEN_W'(1));
  assign wordEnd  = (byteIdx == LANE_W'(LANES - 1));
  assign txData   = dataWord[8*byteIdx +: 8];
  assign txSof    = firstByte;
  assign txEof    = lastByte;
  assign txLoop   = loopSel;

  // R4
  bytes_left_chk: assert property (@(posedge clk) disable iff (!rstN)
    dpCtl.takeByte |-> !lenZero);
endmodule

// File: rtl/desc_tx_ctrl.sv
module desc_tx_ctrl
  import desc_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cfgTxEn,
  input  logic      ctlWrEn,
  input  logic      ctlEnBit,
  input  logic      memValid,
  input  logic      rdEmpty,
  input  logic      lenZero,
  input  logic      lastByte,
  input  logic      wordEnd,
  input  logic      txReady,
  output dp_ctl_t   dpCtl,
  output addr_sel_e addrSel,
  output logic      memReq,
  output logic      memWe,
  output logic      txValid,
  output logic      txEnable,
  output logic      pktSentPulse,
  output logic      underrunPulse
);
  walk_st_e st, nextSt;
  logic     enableQ;
  logic     hitEmpty;
  logic     retDone;

  assign hitEmpty = (st == ST_GET_SIZE) && memValid && rdEmpty;
  assign retDone  = (st == ST_RETURN) && memValid;

  always_comb begin
    dpCtl   = '0;
    addrSel = SEL_DESC_BUF;
    memReq  = 1'b0;
    memWe   = 1'b0;
    txValid = 1'b0;
    nextSt  = st;
    unique case (st)
      ST_IDLE: begin
        if (ctlWrEn && ctlEnBit && cfgTxEn) begin
          dpCtl.startWalk = 1'b1;
          nextSt          = ST_GET_BUF;
        end
      end
      ST_GET_BUF: begin
        memReq = 1'b1;
        if (memValid) begin
          dpCtl.ldBuf = 1'b1;
          nextSt      = ST_GET_SIZE;
        end
      end
      ST_GET_SIZE: begin
        memReq  = 1'b1;
        addrSel = SEL_DESC_SIZE;
        if (memValid) begin
          dpCtl.ldSize = 1'b1;
          nextSt       = rdEmpty ? ST_IDLE : ST_GET_NEXT;
        end
      end
      ST_GET_NEXT: begin
        memReq  = 1'b1;
        addrSel = SEL_DESC_NEXT;
        if (memValid) begin
          dpCtl.ldNext = 1'b1;
          nextSt       = lenZero ? ST_RETURN : ST_GET_WORD;
        end
      end
      ST_GET_WORD: begin
        memReq  = 1'b1;
        addrSel = SEL_PAYLOAD;
        if (memValid) begin
          dpCtl.ldWord = 1'b1;
          nextSt       = ST_SEND;
        end
      end
      ST_SEND: begin
        txValid = 1'b1;
        if (txReady) begin
          dpCtl.takeByte = 1'b1;
          if (lastByte)     nextSt = ST_RETURN;
          else if (wordEnd) nextSt = ST_GET_WORD;
        end
      end
      ST_RETURN: begin
        memReq  = 1'b1;
        memWe   = 1'b1;
        addrSel = SEL_DESC_SIZE;
        if (memValid) begin
          dpCtl.advDesc = 1'b1;
          nextSt        = ST_GET_BUF;
        end
      end
      default: nextSt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st            <= ST_IDLE;
      enableQ       <= 1'b0;
      pktSentPulse  <= 1'b0;
      underrunPulse <= 1'b0;
    end else begin
      st            <= nextSt;
      pktSentPulse  <= retDone;
      underrunPulse <= hitEmpty;
      if (hitEmpty)                     enableQ <= 1'b0;
      else if (st == ST_IDLE && ctlWrEn) enableQ <= ctlEnBit;
    end
  end

  assign txEnable = enableQ;

  // R5
  no_fetch_while_send_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !memReq);

  // R5
  stall_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> txValid);

  // R7
  underrun_clears_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    underrunPulse |-> !txEnable);

  // R6
  sent_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    pktSentPulse |-> $past(memReq && memWe && memValid));

  // R7
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({pktSentPulse, underrunPulse}));
endmodule

// File: rtl/desc_tx_dma.sv
module desc_tx_dma
  import desc_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgTxEn,
  input  logic              cfgLoopback,
  input  logic              ctlWrEn,
  input  logic              ctlEnBit,
  input  logic [ADDR_W-1:0] descPtr,
  output logic              txEnable,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memValid,
  output logic [7:0]        txData,
  output logic              txValid,
  input  logic              txReady,
  output logic              txSof,
  output logic              txEof,
  output logic              txLoop,
  output logic              pktSentPulse,
  output logic              underrunPulse
);
  dp_ctl_t   dpCtl;
  addr_sel_e addrSel;
  logic      rdEmpty, lenZero, lastByte, wordEnd;

  desc_tx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgTxEn(cfgTxEn), .ctlWrEn(ctlWrEn),
    .ctlEnBit(ctlEnBit), .memValid(memValid), .rdEmpty(rdEmpty),
    .lenZero(lenZero), .lastByte(lastByte), .wordEnd(wordEnd),
    .txReady(txReady), .dpCtl(dpCtl), .addrSel(addrSel), .memReq(memReq),
    .memWe(memWe), .txValid(txValid), .txEnable(txEnable),
    .pktSentPulse(pktSentPulse), .underrunPulse(underrunPulse)
  );

  desc_tx_datapath u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .addrSel(addrSel),
    .descPtr(descPtr), .cfgLoopback(cfgLoopback), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .rdEmpty(rdEmpty),
    .lenZero(lenZero), .lastByte(lastByte), .wordEnd(wordEnd),
    .txData(txData), .txSof(txSof), .txEof(txEof), .txLoop(txLoop)
  );

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memValid |=> memReq && $stable(memWe) && $stable(memAddr) && $stable(memWdata));

  // R5
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txReady |=> $stable(txData) && $stable(txSof) && $stable(txEof) && $stable(txLoop));

  // R9
  loop_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    txValid && !txSof |-> $stable(txLoop));
endmodule

// File: tb/sim_desc_tx_dma.sv
module sim_desc_tx_dma;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, cfgTxEn, cfgLoopback, ctlWrEn, ctlEnBit;
  logic [31:0] descPtr, memAddr, memWdata, memRdata;
  logic txEnable, memReq, memWe, memValid;
  logic [7:0] txData;
  logic txValid, txReady, txSof, txEof, txLoop, pktSentPulse, underrunPulse;

  desc_tx_dma u0 (
    .clk(clk), .rstN(rstN), .cfgTxEn(cfgTxEn), .cfgLoopback(cfgLoopback),
    .ctlWrEn(ctlWrEn), .ctlEnBit(ctlEnBit), .descPtr(descPtr),
    .txEnable(txEnable), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memValid(memValid),
    .txData(txData), .txValid(txValid), .txReady(txReady), .txSof(txSof),
    .txEof(txEof), .txLoop(txLoop), .pktSentPulse(pktSentPulse),
    .underrunPulse(underrunPulse)
  );

  int checks = 0, fails = 0;
  int cyc = 0, sentCnt = 0, undCnt = 0, reqCnt = 0, waitCnt = 0;
  int readyMode = 0, slowMem = 0;
  logic armFirst = 1'b0;
  logic [31:0] firstAddr = '0;
  logic [31:0] mem [0:1023];
  logic [10:0] expB [$];
  logic [63:0] expW [$];

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Reference memory, sink and per-cycle comparison.
  initial begin
    memValid = 1'b0; memRdata = '0; txReady = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      case (readyMode)
        0: txReady = 1'b1;
        1: txReady = (cyc % 3) != 0;
        default: txReady = (cyc % 5) >= 2;
      endcase
      memValid = 1'b0;
      if (memReq) begin
        if (waitCnt == 0) begin
          memValid = 1'b1;
          memRdata = mem[memAddr[11:2]];
          waitCnt  = slowMem ? (cyc % 3) : 0;
        end else waitCnt--;
      end
      #1;
      if (memReq) reqCnt++;
      if (armFirst && memReq) begin firstAddr = memAddr; armFirst = 1'b0; end
      if (memValid && memWe) begin
        if (expW.size() == 0) chk(0, "R6 unexpected write", {memAddr, memWdata}, 64'h0);
        else begin
          logic [63:0] e;
          e = expW.pop_front();
          chk({memAddr, memWdata} == e, "R6 write-back", {memAddr, memWdata}, e);
        end
        mem[memAddr[11:2]] = memWdata;
      end
      if (txValid && txReady) begin
        if (expB.size() == 0) chk(0, "R4 unexpected byte", {txLoop, txSof, txEof, txData}, 0);
        else begin
          logic [10:0] e;
          e = expB.pop_front();
          chk({txLoop, txSof, txEof, txData} == e, "R4 R9 byte", {txLoop, txSof, txEof, txData}, e);
        end
      end
      if (pktSentPulse)  sentCnt++;
      if (underrunPulse) undCnt++;
    end
  end

  task automatic addPkt(input int d, input int b, input logic [31:0] sizeW, input int nxt, input int seed);
    int len;
    logic [7:0] v;
    mem[d >> 2] = b;
    mem[(d >> 2) + 1] = sizeW;
    mem[(d >> 2) + 2] = nxt;
    len = int'(sizeW[10:0]);
    for (int i = 0; i < len; i++) begin
      v = 8'((seed + i * 13) & 255);
      mem[(b >> 2) + (i >> 2)][8 * (i % 4) +: 8] = v;
      expB.push_back({cfgLoopback, i == 0, i == len - 1, v});
    end
    expW.push_back({32'(d + 4), sizeW | 32'h8000_0000});
  endtask

  task automatic putEmpty(input int d);
    mem[d >> 2] = '0;
    mem[(d >> 2) + 1] = 32'h8000_0000;
    mem[(d >> 2) + 2] = '0;
  endtask

  task automatic writeCtl(input bit v);
    @(negedge clk);
    ctlWrEn = 1'b1; ctlEnBit = v;
    @(negedge clk);
    ctlWrEn = 1'b0;
  endtask

  task automatic runWalk(input logic [31:0] ptr, input int pkts, input bit midClear);
    int s0, u0c;
    s0 = sentCnt; u0c = undCnt;
    descPtr = ptr;
    armFirst = 1'b1;
    writeCtl(1'b1);
    if (midClear) begin
      repeat (3) @(negedge clk);
      writeCtl(1'b0);
      #2;
      chk(txEnable == 1'b1, "R10 write during walk ignored", txEnable, 1);
    end
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (undCnt != u0c) break;
    end
    @(negedge clk); #2;
    chk(firstAddr == (ptr & 32'hFFFF_FFFC), "R2 first fetch address", firstAddr, ptr & 32'hFFFF_FFFC);
    chk(expB.size() == 0, "R4 bytes left over", expB.size(), 0);
    chk(expW.size() == 0, "R6 write-backs missing", expW.size(), 0);
    chk(sentCnt - s0 == pkts, "R6 sent pulses", sentCnt - s0, pkts);
    chk(undCnt - u0c == 1, "R7 underrun pulses", undCnt - u0c, 1);
    chk(txEnable == 1'b0, "R7 enable cleared", txEnable, 0);
    expB.delete(); expW.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int r0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    rstN = 1'b0; cfgTxEn = 1'b0; cfgLoopback = 1'b0;
    ctlWrEn = 1'b0; ctlEnBit = 1'b0; descPtr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;
    // R1
    chk(!txEnable && !memReq && !txValid && !pktSentPulse && !underrunPulse,
        "R1 reset state", {txEnable, memReq, txValid, pktSentPulse, underrunPulse}, 0);

    // Two packets, free-flowing sink: R2 R4 R6
    cfgTxEn = 1'b1; readyMode = 0; slowMem = 0;
    addPkt('h100, 'h400, 32'd5, 'h110, 3);
    addPkt('h110, 'h440, 32'd8, 'h120, 77);
    putEmpty('h120);
    runWalk(32'h100, 2, 1'b0);

    // Loopback, stalls, unaligned pointers: R2 R5 R6 R9
    cfgLoopback = 1'b1; readyMode = 1; slowMem = 1;
    addPkt('h200, 'h500, 32'd1, 'h212, 10);
    addPkt('h210, 'h520, 32'd4, 'h221, 20);
    addPkt('h220, 'h540, 32'd3, 'h233, 30);
    addPkt('h230, 'h560, 32'd13, 'h240, 40);
    putEmpty('h240);
    runWalk(32'h203, 4, 1'b0);

    // Zero length, length field masking, ignored mid-walk write: R8 R4 R10
    cfgLoopback = 1'b0; readyMode = 2; slowMem = 1;
    addPkt('h300, 'h600, 32'h0000_0000, 'h310, 0);
    addPkt('h310, 'h620, 32'h7C00_F806, 'h320, 99);
    putEmpty('h320);
    runWalk(32'h300, 2, 1'b1);
    // R8
    chk(mem['h304 >> 2] == 32'h8000_0000, "R8 zero-length returned", mem['h304 >> 2], 32'h8000_0000);

    // Empty first descriptor: R7
    readyMode = 0; slowMem = 0;
    putEmpty('h380);
    runWalk(32'h380, 0, 1'b0);

    // Transmit path disabled: R3, then idle clear: R10
    cfgTxEn = 1'b0;
    r0 = reqCnt;
    descPtr = 32'h100;
    writeCtl(1'b1);
    repeat (20) @(negedge clk);
    #2;
    chk(reqCnt == r0, "R3 no fetch while path disabled", reqCnt - r0, 0);
    chk(txEnable == 1'b1, "R3 enable recorded", txEnable, 1);
    writeCtl(1'b0);
    #2;
    chk(txEnable == 1'b0, "R10 idle clear", txEnable, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule